// File: doc/BRIEF.md
# Prescaled Event Counter with Source Select

This block keeps a 32-bit running count of timing events. The events come from one of three places: every system clock cycle, every sixteenth system clock cycle, or each rising edge of an asynchronous external pin. A two-bit select chooses the source, and a fourth code halts counting. The external pin passes through a two-flop synchronizer and then a rising-edge detector, so each pin transition yields exactly one single-cycle event.

The chosen event stream feeds a programmable prescaler. An 8-bit setting P makes it divide by P+1, so any ratio from 1 to 256 is available. Each prescaler output pulse appears on `tick_out` for neighbouring capture and compare logic, and the same pulse advances the count by one.

Software sees the count directly on the `count` output, and looking at it never changes it. A single write strobe, `clr_wr`, returns the count to zero. When a clear and an increment fall in the same cycle, the clear takes precedence.

Top module: `prescaled_event_counter`

## Requirements
- R1: After a clock edge with `rst` high, `count` is 0 and `tick_out` is 0.
- R2: With `clk_sel` = 2'b00, no new `tick_out` pulses occur and `count` holds its value.
- R3: With `clk_sel` = 2'b01 (every cycle is a source event), steady-state counting gives one increment per P+1 clock cycles, where P is `prescale`.
- R4: With `clk_sel` = 2'b10 (one source event per 16 cycles from a free-running divider), steady-state counting gives one increment per 16*(P+1) clock cycles.
- R5: With `clk_sel` = 2'b11, each rising edge of `ext_in` is one source event. A held high or held low level and a falling edge produce no events.
- R6: With `clk_sel` = 2'b11 and P = 0, when `ext_in` is first sampled high at edge k, `tick_out` is high only in the cycle after edge k+2, and `count` has risen by one after edge k+3. The delay from the pin to its effect is therefore two to three clocks.
- R7: The largest setting, P = 255, divides by 256.
- R8: A clock edge with `clr_wr` high leaves `count` at 0, even when an increment was due at that edge.
- R9: `count` advances by exactly one at the edge that ends each `tick_out` cycle. In every other cycle it holds, unless it is cleared.
- R10: The count wraps from its all-ones value to 0.
- R11: If P is lowered below the prescaler's current position, the prescaler wraps at the next source event and emits a pulse. It does not run on to 255 first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Source select: 00 halt, 01 every cycle, 10 every 16 cycles, 11 external pin edges |
| prescale | input | 8 | Prescaler setting P; the divide ratio is P+1 |
| ext_in | input | 1 | Asynchronous external event pin |
| clr_wr | input | 1 | Write strobe that clears the count |
| count | output | CNT_W (32) | Current count value |
| tick_out | output | 1 | Prescaled event pulse |

## Verification
The bench measures the distance between increments exactly, over windows that span whole prescaler periods. A divider that is off by one, that ignores P, or that miscounts the 16-cycle source therefore shows up as a wrong count. The pin path is timed edge by edge. Too few synchronizer stages would give an early pulse, and a level detector instead of an edge detector would keep counting while the pin is held high. The bench clears the count while increments arrive every cycle, so a design where the increment wins would read 1 instead of 0. It also lowers P in the middle of a long period, so a prescaler that compares only for equality would stall for up to 256 events. A narrow-counter instance checks that the count rolls over from all-ones to zero.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef enum logic [1:0] {
    SRC_HALT  = 2'b00,
    SRC_FAST  = 2'b01,
    SRC_SLOW  = 2'b10,
    SRC_PIN   = 2'b11
  } src_sel_e;

  localparam int PRESCALE_W = 8;
  localparam int SLOW_RATIO = 16;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_async};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/src_select.sv
module src_select
  import pec_pkg::*;
#(
  parameter int SLOW_DIV = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  src_sel_e sel,
  input  logic     pin_rise,
  output logic     src_evt
);
  logic slow_evt;

  generate
    if (SLOW_DIV <= 1) begin : g_no_div
      assign slow_evt = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(SLOW_DIV);
      localparam logic [DW-1:0] LAST = DW'(SLOW_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst)                div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end
      assign slow_evt = (div_q == LAST);
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SRC_HALT: src_evt = 1'b0;
      SRC_FAST: src_evt = 1'b1;
      SRC_SLOW: src_evt = slow_evt;
      SRC_PIN:  src_evt = pin_rise;
      default:  src_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/prescale_div.sv
module prescale_div #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] limit,
  input  logic          evt_in,
  output logic          evt_out
);
  logic [PW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      evt_out <= 1'b0;
    end else begin
      evt_out <= 1'b0;
      if (evt_in) begin
        if (pos_q >= limit) begin
          pos_q   <= '0;
          evt_out <= 1'b1;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/event_count.sv
module event_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst || clr) value <= '0;
    else if (inc)   value <= value + 1'b1;
  end
endmodule

// File: rtl/prescaled_event_counter.sv
module prescaled_event_counter
  import pec_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = PRESCALE_W,
  parameter int SLOW_DIV = SLOW_RATIO,
  parameter int SYNC_N = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       clk_sel,
  input  logic [PSC_W-1:0] prescale,
  input  logic             ext_in,
  input  logic             clr_wr,
  output logic [CNT_W-1:0] count,
  output logic             tick_out
);
  logic pin_rise;
  logic src_evt;

  pin_sync_edge #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .pin_async(ext_in), .rise_pulse(pin_rise)
  );

  src_select #(.SLOW_DIV(SLOW_DIV)) u_sel (
    .clk(clk), .rst(rst), .sel(src_sel_e'(clk_sel)),
    .pin_rise(pin_rise), .src_evt(src_evt)
  );

  prescale_div #(.PW(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .limit(prescale),
    .evt_in(src_evt), .evt_out(tick_out)
  );

  event_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr_wr), .inc(tick_out), .value(count)
  );
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       clk_sel,
  input logic             clr_wr,
  input logic [CNT_W-1:0] count,
  input logic             tick_out
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !tick_out));

  assert_halt_R2: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 2'b00) |=> !tick_out);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> (count == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!tick_out && !clr_wr) |=> $stable(count));

  assert_step_R10: assert property (@(posedge clk) disable iff (rst)
    (tick_out && !clr_wr) |=> (count == CNT_W'($past(count) + 1'b1)));
endmodule

bind prescaled_event_counter pec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .clk_sel(clk_sel), .clr_wr(clr_wr),
  .count(count), .tick_out(tick_out)
);

// File: tb/prescaled_event_counter_tb_top.sv
module prescaled_event_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  clk_sel = 2'b00;
  logic [7:0]  prescale = 8'd0;
  logic        ext_in = 1'b0;
  logic        clr_wr = 1'b0;
  logic [31:0] count;
  logic        tick_out;

  logic [1:0]  sel_w = 2'b00;
  logic [7:0]  count_w;
  logic        tick_w;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prescaled_event_counter dut_i (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .prescale(prescale),
    .ext_in(ext_in), .clr_wr(clr_wr), .count(count), .tick_out(tick_out)
  );

  prescaled_event_counter #(.CNT_W(8)) dut_w (
    .clk(clk), .rst(rst), .clk_sel(sel_w), .prescale(8'd0),
    .ext_in(1'b0), .clr_wr(1'b0), .count(count_w), .tick_out(tick_w)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic window(input int n, output logic [31:0] delta, output int ticks);
    logic [31:0] c0;
    c0 = count;
    ticks = 0;
    for (int i = 0; i < n; i++) begin
      if (tick_out) ticks++;
      step();
    end
    delta = count - c0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(3);
    chk("R1 count", count, 0);
    chk("R1 tick", {31'd0, tick_out}, 0);
    rst = 1'b0;
    step();
  endtask

  task automatic t_halt;
    logic [31:0] d;
    int tk;
    clk_sel = 2'b01; prescale = 8'd0;
    step(5);
    clk_sel = 2'b00;
    step(2);
    window(100, d, tk);
    chk("R2 count delta", d, 0);
    chk("R2 tick pulses", tk, 0);
  endtask

  task automatic t_fast;
    logic [31:0] d;
    int tk;
    clk_sel = 2'b01; prescale = 8'd4;
    step(20);
    window(50, d, tk);
    chk("R3 delta P=4", d, 10);
    chk("R9 ticks equal increments", tk, 10);
    prescale = 8'd0;
    step(3);
    window(30, d, tk);
    chk("R3 delta P=0", d, 30);
  endtask

  task automatic t_slow;
    logic [31:0] d;
    int tk;
    clk_sel = 2'b10; prescale = 8'd2;
    step(60);
    window(96, d, tk);
    chk("R4 delta P=2", d, 2);
    prescale = 8'd0;
    step(40);
    window(160, d, tk);
    chk("R4 delta P=0", d, 10);
  endtask

  task automatic t_max_div;
    logic [31:0] d;
    int tk;
    clk_sel = 2'b01; prescale = 8'd255;
    step(300);
    window(512, d, tk);
    chk("R7 divide by 256", d, 2);
  endtask

  task automatic t_pin_latency;
    logic [31:0] c0, d;
    int tk;
    clk_sel = 2'b11; prescale = 8'd0; ext_in = 1'b0;
    step(6);
    c0 = count;
    ext_in = 1'b1;
    step();
    chk("R6 no tick after k", {31'd0, tick_out}, 0);
    step();
    chk("R6 no tick after k+1", {31'd0, tick_out}, 0);
    step();
    chk("R6 tick after k+2", {31'd0, tick_out}, 1);
    chk("R6 count not yet moved", count, c0);
    step();
    chk("R6 count after k+3", count, c0 + 1);
    chk("R6 single pulse", {31'd0, tick_out}, 0);
    window(20, d, tk);
    chk("R5 held high gives nothing", d, 0);
    ext_in = 1'b0;
    window(10, d, tk);
    chk("R5 falling edge gives nothing", d, 0);
  endtask

  task automatic t_pin_prescaled;
    logic [31:0] c0;
    clk_sel = 2'b11; prescale = 8'd2;
    c0 = count;
    for (int i = 0; i < 9; i++) begin
      ext_in = 1'b1; step(3);
      ext_in = 1'b0; step(3);
    end
    step(5);
    chk("R5 nine pin edges through P=2", count - c0, 3);
  endtask

  task automatic t_clear;
    clk_sel = 2'b01; prescale = 8'd0;
    step(5);
    chk("R8 precondition tick active", {31'd0, tick_out}, 1);
    clr_wr = 1'b1;
    step();
    clr_wr = 1'b0;
    chk("R8 clear wins over tick", count, 0);
    step();
    chk("R9 count resumes after clear", count, 1);
    clk_sel = 2'b00;
    step(3);
    clr_wr = 1'b1;
    step();
    clr_wr = 1'b0;
    chk("R8 clear while halted", count, 0);
  endtask

  task automatic t_lower_p;
    int guard;
    int tk;
    clk_sel = 2'b01; prescale = 8'd200;
    guard = 0;
    while (!tick_out && guard < 400) begin step(); guard++; end
    step(100);
    prescale = 8'd10;
    step();
    chk("R11 immediate wrap after lowering", {31'd0, tick_out}, 1);
    tk = 0;
    for (int i = 0; i < 10; i++) begin step(); if (tick_out) tk++; end
    chk("R11 quiet gap", tk, 0);
    step();
    chk("R11 next period of 11", {31'd0, tick_out}, 1);
  endtask

  task automatic t_wrap;
    int guard;
    sel_w = 2'b01;
    guard = 0;
    while (count_w != 8'hFF && guard < 600) begin step(); guard++; end
    chk("R10 reached all ones", {24'd0, count_w}, 32'hFF);
    step();
    chk("R10 wrapped to zero", {24'd0, count_w}, 0);
    sel_w = 2'b00;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_halt();
    t_fast();
    t_slow();
    t_max_div();
    t_pin_latency();
    t_pin_prescaled();
    t_clear();
    t_lower_p();
    t_wrap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule